// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Flags

This block takes a single asynchronous serial line and turns it into bytes. Each frame is one start bit (0) and eight data bits with the least significant bit first. An optional parity bit follows the data, and the frame ends with one stop bit that should be 1. The line is first brought into the clock domain. It is then oversampled at sixteen times the bit rate, and a programmable divisor sets that sample rate. Bits collect in a shift register. When the stop bit has been sampled, the frame result moves to a holding data register or is dropped, according to the error rules.

Four sticky flags report the outcome: data-full, overrun, parity error and framing error. Software reads the data register and the flags through a small register port, and clears each flag by writing 0 to it. Two level interrupt requests, data-ready and error, share one enable input.

Top module: `serial_rx_core`

## Requirements
- R1: After reset all four flags are 0, the data register reads 0 and both interrupt requests are 0.
- R2: A frame with no error copies its byte to the data register (address 0) and sets the full flag. The status register (address 1) holds full in bit 0, overrun in bit 1, parity error in bit 2 and framing error in bit 3. The first data bit on the line becomes bit 0 of the byte.
- R3: With parity enabled, the parity bit makes the count of ones across data and parity bit even (par_odd=0) or odd (par_odd=1). A mismatch sets the parity-error flag and copies the byte, but leaves the full flag unchanged.
- R4: A stop bit sampled as 0 sets the framing-error flag and copies the byte, but leaves the full flag unchanged.
- R5: A frame that completes while the full flag is 1 sets the overrun flag, leaves the data register unchanged and keeps the full flag at 1.
- R6: With parity disabled, the stop bit is the bit directly after the eighth data bit.
- R7: A low pulse on the idle line that is gone before the middle of a bit period is not taken as a start bit and changes no flag.
- R8: irq_rx is 1 exactly while the enable and the full flag are both 1. irq_err is 1 exactly while the enable is 1 and any error flag is 1. With the enable at 0, both are 0.
- R9: Writing 0 to a flag bit of the status register clears that flag only if the flag was read as 1 since it was last set. Writing 1 has no effect.
- R10: Two frames sent with no idle time between them are both received, provided software reads the byte and clears the full flag before the second frame completes.
- R11: The oversampling tick comes every baud_div clock cycles (0 counts as 1), so one bit lasts 16 × baud_div cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial input line, idles at 1 |
| baud_div | input | 16 | Clock cycles per oversampling tick |
| par_en | input | 1 | Parity bit present in each frame |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_irq_en | input | 1 | Enable for both interrupt requests |
| reg_addr | input | 1 | 0 = data register, 1 = status register |
| reg_rd | input | 1 | Read strobe; arms clearing of flags read as 1 |
| reg_wr | input | 1 | Write strobe (status register only) |
| reg_wdata | input | 4 | Status write data; 0 in a bit clears an armed flag |
| reg_rdata | output | 8 | Read data for the selected address |
| irq_rx | output | 1 | Data-ready interrupt request (level) |
| irq_err | output | 1 | Error interrupt request (level) |

## Verification
The bench sends a second frame while the full flag is still set. A design that copied the byte anyway would overwrite the unread data, and one that cleared full would lose the pending byte. Frames with bad parity and with a low stop bit check that the byte is still delivered and that full stays 0. A design that dropped the byte, or raised the data-ready request, would fail there. A short low glitch checks that the start bit is tested again at mid-bit. Clear writes sent without a prior read check that a flag set between a read and a write cannot be lost. A design that cleared on any write of 0 would fail that check.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    localparam int BYTE_W = 8;
    localparam int FLAG_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_frame_t;

    // Status bit positions (bit 0 first)
    localparam int FL_FULL = 0;
    localparam int FL_OVR  = 1;
    localparam int FL_PER  = 2;
    localparam int FL_FER  = 3;

    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    // Bit value that completes the requested parity over the data byte
    function automatic logic parity_of(input logic [BYTE_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b1;
                else if (i == 0) chain[i] <= din;
                else chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_tick.sv
module serial_rx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim = (div == '0) ? DIV_W'(1) : div;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= lim - DIV_W'(1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + DIV_W'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
    import serial_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      line,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      done,
    output rx_frame_t res
);
    localparam int CNT_W = $clog2(OVS);
    localparam int HALF  = OVS / 2;
    localparam int IDX_W = $clog2(BYTE_W);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] shreg;
    logic              perr_q;
    logic              ferr_q;
    logic              full_bit;
    logic              half_bit;

    assign full_bit = (cnt == CNT_W'(OVS - 1));
    assign half_bit = (cnt == CNT_W'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            idx    <= '0;
            shreg  <= '0;
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        cnt <= '0;
                        if (!line) state <= ST_START;
                    end
                    ST_START: begin
                        if (half_bit) begin
                            cnt    <= '0;
                            idx    <= '0;
                            perr_q <= 1'b0;
                            state  <= line ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    ST_DATA: begin
                        if (full_bit) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[BYTE_W-1:1]};
                            if (idx == IDX_W'(BYTE_W - 1))
                                state <= par_en ? ST_PAR : ST_STOP;
                            else
                                idx <= idx + IDX_W'(1);
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    ST_PAR: begin
                        if (full_bit) begin
                            cnt    <= '0;
                            perr_q <= (line != parity_of(shreg, par_odd));
                            state  <= ST_STOP;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    ST_STOP: begin
                        if (full_bit) begin
                            cnt    <= '0;
                            ferr_q <= !line;
                            done   <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign res.data = shreg;
    assign res.perr = perr_q;
    assign res.ferr = ferr_q;
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_frame_t         res,
    input  logic              rie,
    input  logic              addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [FLAG_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [FLAG_W-1:0] flags,
    output logic [BYTE_W-1:0] hold,
    output logic              irq_rx,
    output logic              irq_err
);
    logic [FLAG_W-1:0] armed;
    logic [FLAG_W-1:0] set_v;
    logic [FLAG_W-1:0] clr_v;
    logic              accept;
    logic              rd_stat;
    logic              wr_stat;

    assign accept  = done && !flags[FL_FULL];
    assign rd_stat = rd && (addr == ADDR_STAT);
    assign wr_stat = wr && (addr == ADDR_STAT);

    always_comb begin
        set_v          = '0;
        set_v[FL_OVR]  = done && flags[FL_FULL];
        set_v[FL_PER]  = accept && res.perr;
        set_v[FL_FER]  = accept && res.ferr;
        set_v[FL_FULL] = accept && !res.perr && !res.ferr;
    end

    generate
        for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
            assign clr_v[i] = wr_stat && !wdata[i] && armed[i];
            always_ff @(posedge clk) begin
                if (rst) begin
                    flags[i] <= 1'b0;
                    armed[i] <= 1'b0;
                end else begin
                    if (set_v[i]) flags[i] <= 1'b1;
                    else if (clr_v[i]) flags[i] <= 1'b0;
                    armed[i] <= (clr_v[i] || (set_v[i] && !flags[i])) ? 1'b0
                              : (armed[i] || (rd_stat && flags[i]));
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) hold <= '0;
        else if (accept) hold <= res.data;
    end

    assign rdata   = (addr == ADDR_DATA) ? hold : {{(BYTE_W-FLAG_W){1'b0}}, flags};
    assign irq_rx  = rie && flags[FL_FULL];
    assign irq_err = rie && (flags[FL_OVR] || flags[FL_PER] || flags[FL_FER]);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int OVS         = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rx_irq_en,
    input  logic              reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [FLAG_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq_rx,
    output logic              irq_err
);
    logic              line_s;
    logic              tick;
    logic              frm_done;
    rx_frame_t         frm_res;
    logic [FLAG_W-1:0] flag_q;
    logic [BYTE_W-1:0] hold_q;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(rx_line), .dout(line_s)
    );

    serial_rx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .div(baud_div), .tick(tick)
    );

    serial_rx_frame #(.OVS(OVS)) u_frame (
        .clk(clk), .rst(rst), .tick(tick), .line(line_s),
        .par_en(par_en), .par_odd(par_odd),
        .done(frm_done), .res(frm_res)
    );

    serial_rx_status u_status (
        .clk(clk), .rst(rst), .done(frm_done), .res(frm_res), .rie(rx_irq_en),
        .addr(reg_addr), .rd(reg_rd), .wr(reg_wr), .wdata(reg_wdata),
        .rdata(reg_rdata), .flags(flag_q), .hold(hold_q),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker
    import serial_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              done,
    input rx_frame_t         res,
    input logic [FLAG_W-1:0] flags,
    input logic [BYTE_W-1:0] hold,
    input logic              rie,
    input logic              wr,
    input logic              addr,
    input logic              irq_rx,
    input logic              irq_err
);
    logic st_wr;
    assign st_wr = wr && (addr == ADDR_STAT);

    // R2: clean frame into an empty register
    a_r2_clean_frame_loads: assert property (@(posedge clk) disable iff (rst)
        (done && !flags[FL_FULL] && !res.perr && !res.ferr)
        |=> (flags[FL_FULL] && hold == $past(res.data)));

    // R3 / R4: errored frame still delivers its byte, full untouched
    a_r3_err_frame_copies: assert property (@(posedge clk) disable iff (rst)
        (done && !flags[FL_FULL] && (res.perr || res.ferr))
        |=> (!flags[FL_FULL] && hold == $past(res.data)));

    // R5: overrun keeps the pending byte
    a_r5_overrun_keeps_data: assert property (@(posedge clk) disable iff (rst)
        (done && flags[FL_FULL] && !st_wr)
        |=> (flags[FL_FULL] && flags[FL_OVR] && $stable(hold)));

    // R8: no request while disabled
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
        !rie |-> (!irq_rx && !irq_err));

    // R9: full only drops on a status write
    a_r9_full_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags[FL_FULL] && !st_wr) |=> flags[FL_FULL]);
endmodule

bind serial_rx_core serial_rx_checker u_chk (
    .clk(clk), .rst(rst), .done(frm_done), .res(frm_res), .flags(flag_q),
    .hold(hold_q), .rie(rx_irq_en), .wr(reg_wr), .addr(reg_addr),
    .irq_rx(irq_rx), .irq_err(irq_err)
);

// File: tb/serial_rx_core_test.sv
`timescale 1ns/1ps
module serial_rx_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_line = 1'b1;
    logic [15:0] baud_div = 16'd4;
    logic        par_en = 1'b0;
    logic        par_odd = 1'b0;
    logic        rx_irq_en = 1'b1;
    logic        reg_addr = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_wdata = 4'h0;
    logic [7:0]  reg_rdata;
    logic        irq_rx;
    logic        irq_err;

    always #2.5 clk = ~clk;

    serial_rx_core uut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .baud_div(baud_div),
        .par_en(par_en), .par_odd(par_odd), .rx_irq_en(rx_irq_en),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    typedef struct {
        string      tag;
        logic [3:0] st;
        logic [7:0] dat;
        logic       irx;
        logic       ierr;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    event mon_go, mon_ack;

    // bench model of the flags: bit0 full, bit1 overrun, bit2 parity, bit3 framing
    logic [3:0] m_fl = 4'h0;
    logic [7:0] m_data = 8'h00;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic peek(input logic a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic reg_read(input logic a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic reg_write(input logic [3:0] d);
        @(negedge clk);
        reg_addr = 1'b1;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic clear_all();
        logic [7:0] v;
        reg_read(1'b1, v);
        reg_write(4'h0);
        m_fl = 4'h0;
    endtask

    task automatic hold_bit(input logic b);
        rx_line = b;
        repeat (16 * int'(baud_div)) @(negedge clk);
    endtask

    task automatic drive_frame(input logic [7:0] b, input logic bad_par, input logic bad_stop);
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(b[i]);
        if (par_en) hold_bit(((^b) ^ par_odd) ^ bad_par);
        hold_bit(!bad_stop);
        rx_line = 1'b1;
        repeat (4 * int'(baud_div)) @(negedge clk);
    endtask

    // driver: predicts the outcome, queues it, drives the line, hands off to monitor
    task automatic send(input string tag, input logic [7:0] b, input logic bad_par, input logic bad_stop);
        exp_t e;
        if (m_fl[0]) m_fl[1] = 1'b1;
        else if ((bad_par && par_en) || bad_stop) begin
            m_fl[2] = m_fl[2] | (bad_par && par_en);
            m_fl[3] = m_fl[3] | bad_stop;
            m_data = b;
        end else begin
            m_fl[0] = 1'b1;
            m_data = b;
        end
        e.tag  = tag;
        e.st   = m_fl;
        e.dat  = m_data;
        e.irx  = rx_irq_en & m_fl[0];
        e.ierr = rx_irq_en & (|m_fl[3:1]);
        q.push_back(e);
        drive_frame(b, bad_par, bad_stop);
        ->mon_go;
        @(mon_ack);
    endtask

    // monitor: pops the next expectation and compares against the ports
    initial begin
        forever begin
            exp_t e;
            logic [7:0] v;
            @(mon_go);
            e = q.pop_front();
            peek(1'b1, v);
            check({e.tag, " status"}, {24'h0, v}, {28'h0, e.st});
            peek(1'b0, v);
            check({e.tag, " data"}, {24'h0, v}, {24'h0, e.dat});
            check({e.tag, " irq_rx"}, {31'h0, irq_rx}, {31'h0, e.irx});
            check({e.tag, " irq_err"}, {31'h0, irq_err}, {31'h0, e.ierr});
            ->mon_ack;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R1 reset state
        peek(1'b1, v); check("R1 status", {24'h0, v}, 32'h0);
        peek(1'b0, v); check("R1 data", {24'h0, v}, 32'h0);
        check("R1 irqs", {30'h0, irq_rx, irq_err}, 32'h0);

        // R2 / R6 clean frame, parity off
        send("R2 R6 frame A5", 8'hA5, 1'b0, 1'b0);
        clear_all();

        // R9 clear protocol
        send("R9 frame 3C", 8'h3C, 1'b0, 1'b0);
        reg_write(4'h0);
        peek(1'b1, v); check("R9 write0 without read keeps full", {24'h0, v}, 32'h1);
        reg_read(1'b1, v);
        reg_write(4'hF);
        peek(1'b1, v); check("R9 write1 keeps full", {24'h0, v}, 32'h1);
        reg_write(4'h0);
        m_fl = 4'h0;
        peek(1'b1, v); check("R9 read then write0 clears", {24'h0, v}, 32'h0);

        // R5 overrun
        send("R5 first 55", 8'h55, 1'b0, 1'b0);
        send("R5 overrun 99", 8'h99, 1'b0, 1'b0);
        clear_all();

        // R3 parity
        par_en = 1'b1; par_odd = 1'b0;
        send("R3 even good 0F", 8'h0F, 1'b0, 1'b0);
        clear_all();
        send("R3 even bad 07", 8'h07, 1'b1, 1'b0);
        clear_all();
        par_odd = 1'b1;
        send("R3 odd good 07", 8'h07, 1'b0, 1'b0);
        clear_all();
        send("R3 odd bad E1", 8'hE1, 1'b1, 1'b0);
        clear_all();
        par_en = 1'b0; par_odd = 1'b0;

        // R4 framing
        send("R4 low stop C3", 8'hC3, 1'b0, 1'b1);
        clear_all();

        // R8 gating
        rx_irq_en = 1'b0;
        send("R8 disabled err 5A", 8'h5A, 1'b0, 1'b1);
        clear_all();
        send("R8 disabled good 5B", 8'h5B, 1'b0, 1'b0);
        rx_irq_en = 1'b1;
        #1 check("R8 enable raises irq_rx", {31'h0, irq_rx}, 32'h1);
        clear_all();

        // R7 glitch rejection
        @(negedge clk);
        rx_line = 1'b0;
        repeat (2 * int'(baud_div)) @(negedge clk);
        rx_line = 1'b1;
        repeat (20 * int'(baud_div)) @(negedge clk);
        peek(1'b1, v); check("R7 glitch leaves flags", {24'h0, v}, 32'h0);
        check("R7 glitch no irq", {30'h0, irq_rx, irq_err}, 32'h0);
        send("R7 frame after glitch 6E", 8'h6E, 1'b0, 1'b0);
        clear_all();

        // R10 back-to-back frames, software services the first in between
        fork
            begin
                drive_frame(8'h11, 1'b0, 1'b0);
                drive_frame(8'h22, 1'b0, 1'b0);
            end
            begin
                wait (irq_rx === 1'b1);
                reg_read(1'b0, v);
                check("R10 first byte", {24'h0, v}, 32'h11);
                clear_all();
            end
        join
        m_fl = 4'h1; m_data = 8'h22;
        peek(1'b1, v); check("R10 status after pair", {24'h0, v}, 32'h1);
        peek(1'b0, v); check("R10 second byte", {24'h0, v}, 32'h22);
        clear_all();

        // R11 another divisor
        baud_div = 16'd6;
        repeat (20) @(negedge clk);
        send("R11 div6 frame 81", 8'h81, 1'b0, 1'b0);
        clear_all();

        repeat (10) @(negedge clk);
        summary();
        $finish;
    end
endmodule